// File: doc/BRIEF.md
# Indirect Address Chain Sequencer

This block turns the address field of an instruction into a final 15-bit data address. It follows pointer chains through memory, issues one memory read per defer step, and applies an index offset at one chosen point of the process: either before the chain starts or on the last pointer the chain produced. The index sum itself comes from an adder outside the block. The block drives an operand on a request port and takes the result back in the same cycle.

The mode controller does not send raw mode flags. It sends a resolved policy for deferring and for indexing, plus the order in which the two are applied. With extend mode off, chains can run through any number of levels and stay inside one core. With extend mode on, a chain is exactly one level deep, and the pointer it fetches is a full 15-bit address that may point into another core. Jump-type instructions use plain rules whatever the policy says.

A one-cycle `start` loads the instruction. A one-cycle `done` then marks a valid `eff_addr`, together with the number of defer reads that were used. A chain that grows longer than `MAX_DEFER` is cut off and flagged with `err`.

Top module: `addr_chain_seq`

## Requirements
- R1: With neither deferring nor indexing selected, `eff_addr` equals `cur_core` placed above `instr[11:0]`, and no memory read is made.
- R2: With `ext_mode` low, every fetched word whose bit 12 (the indirect flag) is set causes another read. That read goes to the same core as the first read of the chain, at the word's bits [11:0]. A fetched word with bit 12 clear ends the chain, and its bits [11:0] in that core become the address.
- R3: With `ext_mode` high, a chain makes exactly one read, and bits [14:0] of the fetched word become the address, which may lie in any core.
- R4: `defer_count` equals the number of completed memory reads for the instruction. An indexing step adds no memory read.
- R5: In defer-first order, indexing acts on the final pointer only. The adder operand is `cur_core` above the pointer's bits [11:0] when `ext_mode` is low, and the pointer's bits [14:0] when `ext_mode` is high.
- R6: In index-first order, the adder operand is the instruction field, with `cur_core` above it when `ext_mode` is low and zero above it when high. The sum is the first read address, and its top 3 bits set the core of the rest of the chain.
- R7: When `is_jump` is high, the chain defers only when the indirect flag is set and never indexes. An opcode of 5'b00111 in `instr[17:13]` always counts as having its indirect flag clear.
- R8: `mem_rd` stays high and `mem_addr` stays stable until a cycle in which `mem_ready` is high.
- R9: `done` is high for exactly one cycle per accepted `start`. A `start` that arrives while an instruction is in progress is ignored.
- R10: When a chain would need more than `MAX_DEFER` reads, it stops after `MAX_DEFER` reads, and `err` goes high together with `done`.
- R11: After reset, `done`, `err` and `mem_rd` are low and `defer_count` is zero.
- R12: The index sum is truncated to 15 bits, so an index value carrying a negative two's complement offset wraps the address downward.
- R13: Policy encoding on `defer_pol` and `index_pol`: 0 = never, 1 = only when the indirect flag (`instr[12]`) is set, 2 = always. `index_first` high selects index-first order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load instruction and begin |
| instr | input | 18 | Instruction word |
| cur_core | input | 3 | Current core number |
| ext_mode | input | 1 | Extend mode flag |
| defer_pol | input | 2 | Defer policy (R13) |
| index_pol | input | 2 | Index policy (R13) |
| index_first | input | 1 | Index before deferring |
| is_jump | input | 1 | Instruction is jump-type |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 15 | Memory read address |
| mem_ready | input | 1 | Read data valid |
| mem_data | input | 18 | Read data |
| idx_req | output | 1 | Index adder in use |
| idx_operand | output | 15 | Adder operand |
| idx_sum | input | 15 | Adder result, same cycle |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Chain limit reached |
| eff_addr | output | 15 | Effective address |
| defer_count | output | CNT_W | Defer reads used |

## Verification
The bench builds the block with `MAX_DEFER` set to 4. With that value, a word that points back to itself reaches the abort after only four reads, while the three-level chains still finish normally. The memory model's response latency is changed between runs, from zero to three wait cycles. This makes the stable-address rule apply to multi-cycle waits. The index register value is also changed, to cover cross-core sums and a two's complement wrap.

// File: rtl/acs_pkg.sv
package acs_pkg;
    localparam int WORD_W   = 18;
    localparam int ADDR_W   = 15;
    localparam int FIELD_W  = 12;
    localparam int CORE_W   = ADDR_W - FIELD_W;
    localparam int IBIT_POS = 12;
    localparam int OP_W     = 5;
    localparam logic [OP_W-1:0] OP_NO_IND = 5'b00111;

    typedef enum logic [1:0] {
        POL_NEVER  = 2'd0,
        POL_IBIT   = 2'd1,
        POL_ALWAYS = 2'd2
    } pol_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INDEX,
        ST_READ,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic defer;
        logic index;
        logic idx_first;
    } plan_t;

    function automatic logic pol_hit(input logic [1:0] p, input logic ib);
        return (p == POL_ALWAYS) || ((p == POL_IBIT) && ib);
    endfunction

    function automatic logic [ADDR_W-1:0] join_addr(input logic [CORE_W-1:0] c,
                                                     input logic [FIELD_W-1:0] f);
        return {c, f};
    endfunction
endpackage

// File: rtl/acs_plan.sv
module acs_plan
    import acs_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    input  logic [1:0]        defer_pol,
    input  logic [1:0]        index_pol,
    input  logic              index_first,
    input  logic              is_jump,
    output plan_t             plan
);
    logic ib;

    always_comb begin
        ib = instr[IBIT_POS] && (instr[WORD_W-1 -: OP_W] != OP_NO_IND);
        if (is_jump) begin
            plan.defer     = ib;
            plan.index     = 1'b0;
            plan.idx_first = 1'b0;
        end else begin
            plan.defer     = pol_hit(defer_pol, ib);
            plan.index     = pol_hit(index_pol, ib);
            plan.idx_first = index_first;
        end
    end
endmodule

// File: rtl/acs_defer_ctr.sv
module acs_defer_ctr #(
    parameter  int MAX_DEFER = 8,
    localparam int CNT_W     = $clog2(MAX_DEFER + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end

    assign last = (count == CNT_W'(MAX_DEFER - 1));
endmodule

// File: rtl/addr_chain_seq.sv
module addr_chain_seq
    import acs_pkg::*;
#(
    parameter  int MAX_DEFER = 8,
    localparam int CNT_W     = $clog2(MAX_DEFER + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [17:0]       instr,
    input  logic [2:0]        cur_core,
    input  logic              ext_mode,
    input  logic [1:0]        defer_pol,
    input  logic [1:0]        index_pol,
    input  logic              index_first,
    input  logic              is_jump,
    output logic              mem_rd,
    output logic [14:0]       mem_addr,
    input  logic              mem_ready,
    input  logic [17:0]       mem_data,
    output logic              idx_req,
    output logic [14:0]       idx_operand,
    input  logic [14:0]       idx_sum,
    output logic              done,
    output logic              err,
    output logic [14:0]       eff_addr,
    output logic [CNT_W-1:0]  defer_count
);
    st_e                state;
    logic [ADDR_W-1:0]  ptr;
    logic [CORE_W-1:0]  chain_core;
    logic [CORE_W-1:0]  home_core;
    logic               ext_q;
    logic               read_next;
    logic               index_after;
    logic               err_q;
    plan_t              plan;
    logic               accept;
    logic               ctr_inc;
    logic               ctr_last;
    logic               chain_more;
    logic [FIELD_W-1:0] fld;
    logic [ADDR_W-1:0]  tail_ptr;
    logic [ADDR_W-1:0]  idx_in_ptr;

    acs_plan u_plan (
        .instr       (instr),
        .defer_pol   (defer_pol),
        .index_pol   (index_pol),
        .index_first (index_first),
        .is_jump     (is_jump),
        .plan        (plan)
    );

    assign accept  = (state == ST_IDLE) && start;
    assign ctr_inc = (state == ST_READ) && mem_ready;

    acs_defer_ctr #(.MAX_DEFER(MAX_DEFER)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .inc   (ctr_inc),
        .count (defer_count),
        .last  (ctr_last)
    );

    always_comb begin
        fld        = instr[FIELD_W-1:0];
        chain_more = mem_data[IBIT_POS] && !ext_q;
        tail_ptr   = ext_q ? mem_data[ADDR_W-1:0]
                           : join_addr(chain_core, mem_data[FIELD_W-1:0]);
        idx_in_ptr = ext_q ? mem_data[ADDR_W-1:0]
                           : join_addr(home_core, mem_data[FIELD_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            ptr         <= '0;
            chain_core  <= '0;
            home_core   <= '0;
            ext_q       <= 1'b0;
            read_next   <= 1'b0;
            index_after <= 1'b0;
            err_q       <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        home_core   <= cur_core;
                        chain_core  <= cur_core;
                        ext_q       <= ext_mode;
                        err_q       <= 1'b0;
                        index_after <= plan.index && plan.defer && !plan.idx_first;
                        if (plan.index && (plan.idx_first || !plan.defer)) begin
                            ptr       <= ext_mode ? join_addr('0, fld)
                                                  : join_addr(cur_core, fld);
                            read_next <= plan.defer;
                            state     <= ST_INDEX;
                        end else begin
                            ptr   <= join_addr(cur_core, fld);
                            state <= plan.defer ? ST_READ : ST_DONE;
                        end
                    end
                end
                ST_INDEX: begin
                    ptr        <= idx_sum;
                    chain_core <= idx_sum[ADDR_W-1 -: CORE_W];
                    read_next  <= 1'b0;
                    state      <= read_next ? ST_READ : ST_DONE;
                end
                ST_READ: begin
                    if (mem_ready) begin
                        if (chain_more) begin
                            if (ctr_last) begin
                                err_q <= 1'b1;
                                state <= ST_DONE;
                            end else begin
                                ptr <= join_addr(chain_core, mem_data[FIELD_W-1:0]);
                            end
                        end else if (index_after) begin
                            ptr         <= idx_in_ptr;
                            index_after <= 1'b0;
                            state       <= ST_INDEX;
                        end else begin
                            ptr   <= tail_ptr;
                            state <= ST_DONE;
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd      = (state == ST_READ);
    assign mem_addr    = ptr;
    assign idx_req     = (state == ST_INDEX);
    assign idx_operand = ptr;
    assign done        = (state == ST_DONE);
    assign err         = done && err_q;
    assign eff_addr    = ptr;
endmodule

// File: rtl/acs_chk.sv
module acs_chk #(
    parameter  int MAX_DEFER = 8,
    localparam int CNT_W     = $clog2(MAX_DEFER + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_rd,
    input logic             mem_ready,
    input logic [14:0]      mem_addr,
    input logic             idx_req,
    input logic             done,
    input logic             err,
    input logic [CNT_W-1:0] defer_count
);
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr))); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_rd && !idx_req)); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_ready) |=> (defer_count == CNT_W'($past(defer_count) + 1'b1))); // R4
    AST_INDEX_NO_READ: assert property (@(posedge clk) disable iff (rst)
        idx_req |-> !mem_rd); // R4
    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (rst)
        defer_count <= CNT_W'(MAX_DEFER)); // R10
    AST_ERR_AT_CAP: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && defer_count == CNT_W'(MAX_DEFER))); // R10
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !mem_rd && !err)); // R11
endmodule

bind addr_chain_seq acs_chk #(.MAX_DEFER(MAX_DEFER)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_rd      (mem_rd),
    .mem_ready   (mem_ready),
    .mem_addr    (mem_addr),
    .idx_req     (idx_req),
    .done        (done),
    .err         (err),
    .defer_count (defer_count)
);

// File: tb/sim_addr_chain_seq.sv
`timescale 1ns/1ps
module sim_addr_chain_seq;
    localparam int MAXD = 4;
    localparam int CW   = $clog2(MAXD + 1);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [17:0]   instr = '0;
    logic [2:0]    cur_core = '0;
    logic          ext_mode = 1'b0;
    logic [1:0]    defer_pol = '0;
    logic [1:0]    index_pol = '0;
    logic          index_first = 1'b0;
    logic          is_jump = 1'b0;
    logic          mem_rd;
    logic [14:0]   mem_addr;
    logic          mem_ready = 1'b0;
    logic [17:0]   mem_data = '0;
    logic          idx_req;
    logic [14:0]   idx_operand;
    logic [14:0]   idx_sum;
    logic          done;
    logic          err;
    logic [14:0]   eff_addr;
    logic [CW-1:0] defer_count;

    logic [17:0] xreg = '0;
    logic [17:0] mem [int];
    int lat = 0;
    int checks = 0;
    int fails = 0;
    int cycles = 0;

    assign idx_sum = idx_operand + xreg[14:0];

    addr_chain_seq #(.MAX_DEFER(MAXD)) u0 (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .cur_core(cur_core),
        .ext_mode(ext_mode), .defer_pol(defer_pol), .index_pol(index_pol),
        .index_first(index_first), .is_jump(is_jump), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_data(mem_data),
        .idx_req(idx_req), .idx_operand(idx_operand), .idx_sum(idx_sum),
        .done(done), .err(err), .eff_addr(eff_addr), .defer_count(defer_count)
    );

    typedef struct {
        logic [14:0] ea;
        int          cnt;
        bit          err;
        string       req;
    } exp_t;
    exp_t sbq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0o expected=%0o", req, what, act, exp);
        end
    endtask

    function automatic logic [17:0] rd_mem(input int a);
        return mem.exists(a) ? mem[a] : 18'o0;
    endfunction

    // Reference from the requirements (R1-R7, R10, R12, R13 encodings)
    function automatic exp_t model(input logic [17:0] ins, input logic [2:0] core,
                                   input bit ext, input logic [1:0] dp, input logic [1:0] ip,
                                   input bit first, input bit jump, input string req);
        exp_t e;
        bit ib, d, x, more;
        logic [14:0] p;
        logic [2:0] cc;
        logic [17:0] w;
        ib = ins[12] && (ins[17:13] != 5'b00111);
        if (jump) begin d = ib; x = 1'b0; end
        else begin
            d = (dp == 2'd2) || (dp == 2'd1 && ib);
            x = (ip == 2'd2) || (ip == 2'd1 && ib);
        end
        p = {core, ins[11:0]};
        cc = core;
        w = '0;
        e.cnt = 0; e.err = 1'b0; e.req = req;
        if (x && (first || !d)) begin
            p = (ext ? {3'b000, ins[11:0]} : {core, ins[11:0]}) + xreg[14:0];
            cc = p[14:12];
        end
        if (d) begin
            more = 1'b1;
            while (more) begin
                w = rd_mem(int'(p));
                e.cnt++;
                if (ext) begin p = w[14:0]; more = 1'b0; end
                else if (w[12]) begin
                    if (e.cnt == MAXD) begin e.err = 1'b1; more = 1'b0; end
                    p = {cc, w[11:0]};
                end else begin p = {cc, w[11:0]}; more = 1'b0; end
            end
            if (!e.err && x && !first)
                p = (ext ? w[14:0] : {core, w[11:0]}) + xreg[14:0];
        end
        e.ea = p;
        return e;
    endfunction

    task automatic drive(input logic [17:0] ins, input logic [2:0] core, input bit ext,
                         input logic [1:0] dp, input logic [1:0] ip, input bit first,
                         input bit jump);
        @(negedge clk);
        instr = ins; cur_core = core; ext_mode = ext; defer_pol = dp;
        index_pol = ip; index_first = first; is_jump = jump; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input string req, input logic [17:0] ins, input logic [2:0] core,
                       input bit ext, input logic [1:0] dp, input logic [1:0] ip,
                       input bit first, input bit jump);
        sbq.push_back(model(ins, core, ext, dp, ip, first, jump, req));
        drive(ins, core, ext, dp, ip, first, jump);
        while (sbq.size() != 0) @(negedge clk);
    endtask

    // Memory responder with address-stability check (R8)
    initial begin
        bit pend = 1'b0;
        logic [14:0] paddr = '0;
        int wcnt = 0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0; pend = 1'b0; wcnt = 0;
            end else if (mem_rd) begin
                if (pend) check(mem_addr == paddr, "R8", "held address", int'(mem_addr), int'(paddr));
                pend = 1'b1; paddr = mem_addr;
                if (wcnt >= lat) begin
                    mem_ready = 1'b1; mem_data = rd_mem(int'(mem_addr)); wcnt = 0;
                end else wcnt++;
            end
        end
    end

    // Monitor / scoreboard (R4, R9, R10)
    initial begin
        bit prev_done = 1'b0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (done) begin
                if (prev_done) check(1'b0, "R9", "done longer than one cycle", 1, 0);
                if (sbq.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    e = sbq.pop_front();
                    if (!e.err) check(eff_addr == e.ea, e.req, "eff_addr", int'(eff_addr), int'(e.ea));
                    check(int'(defer_count) == e.cnt, "R4", "defer_count", int'(defer_count), e.cnt);
                    check(err == e.err, "R10", "err flag", int'(err), int'(e.err));
                end
            end
            prev_done = done;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                check(1'b0, "watchdog", "run timed out", cycles, 100000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!done && !err && !mem_rd, "R11", "outputs quiet after reset",
              int'({done, err, mem_rd}), 0);
        check(defer_count == '0, "R11", "count zero", int'(defer_count), 0);

        // memory contents
        mem[15'o21234] = 18'o052105; mem[15'o22105] = 18'o013224;
        mem[15'o23224] = 18'o004256; mem[15'o11234] = 18'o052105;
        mem[15'o30130] = 18'o011234; mem[15'o31234] = 18'o062345;
        mem[15'o10130] = 18'o031234; mem[15'o20030] = 18'o011234;
        mem[15'o21234] = 18'o002345; mem[15'o00040] = 18'o000500;
        mem[15'o40100] = 18'o010100;

        // R1 direct
        run("R1", 18'o201234, 3'd1, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0);
        // R2 multi-level chain, slow memory
        lat = 2;
        mem[15'o21234] = 18'o052105;
        run("R2", 18'o211234, 3'd2, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0);
        // R3 single-level cross-core
        lat = 0;
        run("R3", 18'o211234, 3'd1, 1'b1, 2'd1, 2'd0, 1'b0, 1'b0);
        // R6 index-first, ext off and on
        xreg = 18'o010100;
        run("R6", 18'o210030, 3'd2, 1'b0, 2'd1, 2'd2, 1'b1, 1'b0);
        run("R6", 18'o210030, 3'd2, 1'b1, 2'd1, 2'd2, 1'b1, 1'b0);
        // R5 defer-first, ext off and on
        mem[15'o21234] = 18'o002345;
        lat = 3;
        run("R5", 18'o210030, 3'd2, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0);
        run("R5", 18'o210030, 3'd2, 1'b1, 2'd2, 2'd1, 1'b0, 1'b0);
        // R13 index only on indirect flag, defer never
        lat = 1;
        run("R13", 18'o210030, 3'd2, 1'b0, 2'd0, 2'd1, 1'b0, 1'b0);
        run("R13", 18'o200030, 3'd2, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0);
        // R7 jump ignores index policy; no-indirect opcode
        run("R7", 18'o110040, 3'd0, 1'b0, 2'd0, 2'd2, 1'b1, 1'b1);
        run("R7", 18'o171234, 3'd5, 1'b0, 2'd2, 2'd2, 1'b0, 1'b1);
        // R12 two's complement wrap of index sum
        xreg = 18'o777770;
        run("R12", 18'o200070, 3'd0, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0);
        // R10 circular chain aborts
        run("R10", 18'o210100, 3'd4, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0);
        // R9 start while busy is ignored
        lat = 3;
        mem[15'o21234] = 18'o052105;
        sbq.push_back(model(18'o211234, 3'd2, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, "R9"));
        drive(18'o211234, 3'd2, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0);
        drive(18'o201111, 3'd6, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0);
        while (sbq.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        check(sbq.size() == 0 && !done, "R9", "no second result", int'(done), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule